// File: doc/BRIEF.md
# Double-Edge Serial Lane Deserializer with Word Buffer

This block takes one serial data lane clocked by a fast bit clock and samples it on both clock edges, so every bit-clock period yields two bits. Samples taken on the rising edge and samples taken on the falling edge are held in two separate capture registers. Each capture register feeds its own nibble shifter. The two nibbles are interleaved into an 8-bit word, with the earliest received bit in bit 0.

A clock enable that runs at half the bit-clock rate paces the transfer of completed words. Each word is written into a 16-entry dual-port RAM. An independent, slower read clock drains the RAM. Write and read pointers cross between the two clock domains as Gray codes through two-flop synchronizers. A full flag blocks writes, and any blocked write sets a sticky overflow flag. An empty flag blocks reads.

Each domain has its own synchronous reset, which clears the shifters, pointers and flags. After reset release, the lane produces one word every four bit-clock periods for as long as it runs.

Top module: `ddr_deser_buf`

## Requirements
- R1: In every word, bit 2k holds the k-th rising-edge sample of that word and bit 2k+1 holds the k-th falling-edge sample. The earliest of the word's eight bits lands in bit 0, so a lane carrying bytes least-significant bit first gives back those same bytes.
- R2: The first rising edge after reset release captures the first bit. The first word is written at the sixth rising edge after release, once eight fresh bits have been shifted in. No word is written before that edge.
- R3: After the first write, exactly one word is offered every four bit-clock periods. Each write falls on a cycle where the half-rate clock enable is high.
- R4: The buffer holds 16 words. With no reads, `full` is low after the 15th write and rises at the 16th write, which is the 66th rising edge after release.
- R5: A word offered while `full` is high is dropped and sets `overflow`. The flag stays set until write reset. The stored words are not disturbed and read back unchanged.
- R6: Words are read in write order. A read accepted on a rising edge of `rdClk` (with `rdEn` high and `empty` low) presents the word on `rdData` with `rdValid` high after that same edge.
- R7: A read request while `empty` is high is ignored: `rdValid` stays low and no pointer moves.
- R8: While the resets are held, `empty` reads 1 and `full`, `overflow` and `rdValid` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Fast bit clock; lane sampled on both edges |
| wrRst | input | 1 | Synchronous reset, bit-clock domain |
| serIn | input | 1 | Serial data lane |
| full | output | 1 | Buffer full (bit-clock domain) |
| overflow | output | 1 | Sticky: a word was dropped because the buffer was full |
| rdClk | input | 1 | Independent read clock |
| rdRst | input | 1 | Synchronous reset, read domain |
| rdEn | input | 1 | Read request |
| rdData | output | 8 | Word read from the buffer |
| rdValid | output | 1 | rdData holds a newly read word |
| empty | output | 1 | Buffer empty (read domain) |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, giving 8-bit words, and a buffer of 2^4 entries. With these values, filling the buffer without reads takes only about seventy bit-clock cycles. That makes the exact edges of the first write, the full flag and the first dropped word checkable by counting edges. The read clock runs at a quarter of the bit-clock rate, so the buffer fills while a reader drains it. Word patterns with different rising and falling halves check the interleave order.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  typedef struct packed {
    logic shiftEn;   // capture registers hold a fresh pair
    logic wrStrobe;  // nibbles hold a complete word
    logic halfEn;    // half-rate transfer enable
  } ctlStrobes_t;

  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/ddr_deser_ctrl.sv
module ddr_deser_ctrl
  import ddr_deser_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic        bitClk,
  input  logic        wrRst,
  output ctlStrobes_t ctl
);
  localparam int PH_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_W - 1);

  logic            primed;
  logic [PH_W-1:0] phase;
  logic            wrStrobeQ;
  logic            halfEnQ;

  always_ff @(posedge bitClk) begin
    if (wrRst) begin
      primed    <= 1'b0;
      phase     <= '0;
      wrStrobeQ <= 1'b0;
      halfEnQ   <= 1'b0;
    end else begin
      primed    <= 1'b1;
      halfEnQ   <= primed ? ~halfEnQ : 1'b1;
      wrStrobeQ <= primed && (phase == PH_LAST);
      if (primed) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    ctl.shiftEn  = primed;
    ctl.wrStrobe = wrStrobeQ;
    ctl.halfEn   = halfEnQ;
  end

  // R3
  strobe_on_half_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    ctl.wrStrobe |-> ctl.halfEn);
  // R3
  strobe_single_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    ctl.wrStrobe |=> !ctl.wrStrobe);
  // R3
  half_toggle_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    $past(ctl.shiftEn) && ctl.shiftEn |-> ctl.halfEn != $past(ctl.halfEn));

endmodule

// File: rtl/ddr_deser_dp.sv
module ddr_deser_dp
  import ddr_deser_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int WORD_W = 2 * NIB_W
) (
  input  logic              bitClk,
  input  logic              wrRst,
  input  logic              serIn,
  input  ctlStrobes_t       ctl,
  output logic [WORD_W-1:0] word
);
  logic             riseCap;
  logic             fallCap;
  logic [NIB_W-1:0] riseNib;
  logic [NIB_W-1:0] fallNib;

  always_ff @(posedge bitClk) begin
    if (wrRst) riseCap <= 1'b0;
    else       riseCap <= serIn;
  end

  always_ff @(negedge bitClk) begin
    if (wrRst) fallCap <= 1'b0;
    else       fallCap <= serIn;
  end

  // newest pair enters at the top; after NIB_W shifts the oldest sits in bit 0
  always_ff @(posedge bitClk) begin
    if (wrRst) begin
      riseNib <= '0;
      fallNib <= '0;
    end else if (ctl.shiftEn) begin
      riseNib <= {riseCap, riseNib[NIB_W-1:1]};
      fallNib <= {fallCap, fallNib[NIB_W-1:1]};
    end
  end

  for (genvar k = 0; k < NIB_W; k++) begin : g_weave
    assign word[2*k]     = riseNib[k];
    assign word[2*k + 1] = fallNib[k];
  end

  // R2
  strobe_after_shift_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    ctl.wrStrobe |-> ctl.shiftEn);

endmodule

// File: rtl/ddr_deser_fifo.sv
module ddr_deser_fifo
  import ddr_deser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              bitClk,
  input  logic              wrRst,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] wrWord,
  output logic              full,
  output logic              overflow,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];

  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync1, rdGraySync2;
  logic [PTR_W-1:0] rdBin, rdGray, wrGraySync1, wrGraySync2;
  logic [PTR_W-1:0] wrBinNext, rdBinNext;
  logic [15:0]      wrGrayWide, rdGrayWide;

  assign wrBinNext  = wrBin + 1'b1;
  assign rdBinNext  = rdBin + 1'b1;
  assign wrGrayWide = bin2gray(16'(wrBinNext));
  assign rdGrayWide = bin2gray(16'(rdBinNext));

  // write domain
  assign full = (wrGray == {~rdGraySync2[PTR_W-1:PTR_W-2], rdGraySync2[PTR_W-3:0]});

  always_ff @(posedge bitClk) begin
    if (wrRst) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
      overflow    <= 1'b0;
    end else begin
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
      if (ctl.wrStrobe) begin
        if (full) begin
          overflow <= 1'b1;
        end else begin
          wrBin  <= wrBinNext;
          wrGray <= wrGrayWide[PTR_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge bitClk) begin
    if (ctl.wrStrobe && !full) mem[wrBin[ADDR_W-1:0]] <= wrWord;
  end

  // read domain
  assign empty = (rdGray == wrGraySync2);

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
      rdValid     <= 1'b0;
      rdData      <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
      rdValid     <= rdEn && !empty;
      if (rdEn && !empty) begin
        rdData <= mem[rdBin[ADDR_W-1:0]];
        rdBin  <= rdBinNext;
        rdGray <= rdGrayWide[PTR_W-1:0];
      end
    end
  end

  // R5
  overflow_set_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    ctl.wrStrobe && full |=> overflow);
  // R5
  overflow_sticky_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    overflow |=> overflow);
  // R5
  no_overflow_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    ctl.wrStrobe && full |=> $stable(wrBin));
  // R4
  wr_gray_step_chk: assert property (@(posedge bitClk) disable iff (wrRst)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  // R7
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    empty |=> !rdValid && $stable(rdBin));
  // R6
  read_valid_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    rdEn && !empty |=> rdValid);

endmodule

// File: rtl/ddr_deser_buf.sv
module ddr_deser_buf
  import ddr_deser_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2 * NIB_W
) (
  input  logic              bitClk,
  input  logic              wrRst,
  input  logic              serIn,
  output logic              full,
  output logic              overflow,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty
);
  ctlStrobes_t       ctl;
  logic [WORD_W-1:0] word;

  ddr_deser_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .bitClk(bitClk), .wrRst(wrRst), .ctl(ctl)
  );

  ddr_deser_dp #(.NIB_W(NIB_W)) u_dp (
    .bitClk(bitClk), .wrRst(wrRst), .serIn(serIn), .ctl(ctl), .word(word)
  );

  ddr_deser_fifo #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fifo (
    .bitClk(bitClk), .wrRst(wrRst), .ctl(ctl), .wrWord(word),
    .full(full), .overflow(overflow),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .empty(empty)
  );

endmodule

// File: tb/tb_ddr_deser_buf.sv
module tb_ddr_deser_buf;
  localparam int BIT_HALF  = 5;
  localparam int BIT_PERIOD = 2 * BIT_HALF;
  localparam int RD_PERIOD  = 4 * BIT_PERIOD;
  localparam int NWORDS     = 40;

  logic bitClk = 1'b0, rdClk = 1'b0;
  logic wrRst = 1'b1, rdRst = 1'b1, serIn = 1'b0, rdEn = 1'b0;
  logic full, overflow, rdValid, empty;
  logic [7:0] rdData;

  int checks = 0, fails = 0, idx = 0;
  bit done = 1'b0;
  logic [7:0] streamWords [NWORDS];

  always #(BIT_HALF) bitClk = ~bitClk;
  always #(RD_PERIOD / 2) rdClk = ~rdClk;

  ddr_deser_buf dut (
    .bitClk(bitClk), .wrRst(wrRst), .serIn(serIn), .full(full), .overflow(overflow),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .empty(empty)
  );

  function automatic logic bitAt(int i);
    return streamWords[(i / 8) % NWORDS][i % 8];
  endfunction

  // lane driver: set after a falling edge for the next rising edge, and vice versa
  initial begin
    forever begin
      @(negedge bitClk); #1; serIn = bitAt(idx); idx++;
      @(posedge bitClk); #1; serIn = bitAt(idx); idx++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    wrRst = 1'b1; rdRst = 1'b1; rdEn = 1'b0;
    repeat (3) @(posedge rdClk);
    @(posedge bitClk); #2;
    idx = 0; wrRst = 1'b0; rdRst = 1'b0;
  endtask

  task automatic readWords(int n, int first, string req);
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      @(negedge rdClk);
      while (empty && guard < 200) begin @(negedge rdClk); guard++; end
      rdEn = 1'b1;
      @(negedge rdClk);
      rdEn = 1'b0;
      check(rdValid == 1'b1, req, rdValid, 1);
      check(rdData == streamWords[first + i], req, rdData, streamWords[first + i]);
    end
  endtask

  task automatic testReset();
    wrRst = 1'b1; rdRst = 1'b1; rdEn = 1'b0;
    repeat (3) @(posedge rdClk);
    @(negedge rdClk);
    check(empty == 1'b1, "R8", empty, 1);
    check(full == 1'b0, "R8", full, 0);
    check(overflow == 1'b0, "R8", overflow, 0);
    check(rdValid == 1'b0, "R8", rdValid, 0);
  endtask

  task automatic testEmptyRead();
    doReset();
    @(negedge rdClk);
    check(empty == 1'b1, "R7", empty, 1);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    check(rdValid == 1'b0, "R7", rdValid, 0);
    check(empty == 1'b1, "R7", empty, 1);
  endtask

  task automatic testOrder();
    streamWords[0] = 8'h55; streamWords[1] = 8'hAA; streamWords[2] = 8'h0F;
    streamWords[3] = 8'hF0; streamWords[4] = 8'h01; streamWords[5] = 8'h80;
    streamWords[6] = 8'hC3; streamWords[7] = 8'h5A;
    doReset();
    readWords(8, 0, "R1/R6");
  endtask

  task automatic testFillTiming();
    for (int i = 0; i < NWORDS; i++) streamWords[i] = 8'(i * 37 + 11);
    doReset();
    repeat (4) @(posedge bitClk); #2;
    check(empty == 1'b1, "R2", empty, 1);
    check(full == 1'b0, "R2", full, 0);
    repeat (61) @(posedge bitClk); #2;
    check(full == 1'b0, "R3", full, 0);
    @(posedge bitClk); #2;
    check(full == 1'b1, "R4", full, 1);
    check(overflow == 1'b0, "R4", overflow, 0);
    repeat (3) @(posedge bitClk); #2;
    check(overflow == 1'b0, "R5", overflow, 0);
    @(posedge bitClk); #2;
    check(overflow == 1'b1, "R5", overflow, 1);
    readWords(16, 0, "R5");
    check(overflow == 1'b1, "R5", overflow, 1);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) streamWords[i] = 8'(i);
    testReset();
    testEmptyRead();
    testOrder();
    testFillTiming();
    testReset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200_000 * BIT_PERIOD);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule